// File: doc/BRIEF.md
# Buffered flash program sequencer

This block writes a run of data words into a NOR flash through the device's write-buffer programming sequence. A host hands it a start byte address and a word count. It then streams the data words over a valid/ready channel. The sequencer drives single-cycle write and read strobes on a simple synchronous flash bus. It first waits for the device to report ready, then opens a buffer load, sends the length and the data, and confirms. It waits a self-tuned delay, polls for completion, and turns the status byte into a result code that it holds until the host acknowledges it.

A host request may be longer than the device's write buffer, or it may start part-way into one. In either case the sequencer cuts the request into bursts, and each burst stops at the next buffer boundary. The buffer size in bytes is the interleave factor shifted left by the buffer-size exponent. Each burst runs the full command sequence against the buffer-aligned address that contains it.

The controller is a single state machine with these states. IDLE accepts a request. STAT writes the status-read command. PREPOLL waits for ready. BUFCMD opens the buffer. BUFPOLL waits for buffer ready. COUNT sends the length. DATA streams words. CONFIRM starts programming. WAIT spends the delay estimate. DONEPOLL polls for completion. CLEAR writes clear-status. RESTAT writes the status-read command again. REPORT holds the result.

The transitions are as follows. IDLE goes to REPORT on a misaligned address or a zero count, and to STAT otherwise. STAT goes to PREPOLL. PREPOLL goes to BUFCMD on ready, or to REPORT on timeout. BUFCMD goes to BUFPOLL. BUFPOLL goes to COUNT on ready, or to RESTAT on timeout. COUNT goes to DATA. DATA goes to CONFIRM after the last word. CONFIRM goes to WAIT. WAIT goes to DONEPOLL when the count expires. DONEPOLL goes to CLEAR on an error or a timeout, to STAT when more words remain, and to REPORT when the request is complete. CLEAR goes to RESTAT. RESTAT goes to REPORT. REPORT goes to IDLE on acknowledge.

Top module: `flprog_seq`

## Requirements
- R1: A request whose start address is not a multiple of the bus width in bytes (2 by default) ends at once with result 4 (misaligned). It makes no flash bus cycle and takes no data word. A request with a word count of 0 ends at once with result 0 and no bus cycle.
- R2: Each burst begins by writing 0x70 to its buffer-aligned command address. It then reads status every cycle until bit 7 is set. If 64 reads (POLL_LIMIT) pass without ready, the request ends with result 3 (timeout) and no further write.
- R3: Once the device is ready, the block writes 0xE8 to the command address and polls for bit 7. If POLL_LIMIT reads pass without ready, it writes 0x70 to the command address and ends with result 3.
- R4: After buffer ready, the block writes the burst word count minus one to the command address. It then writes each data word at the burst start address plus 2 bytes per word, and then writes 0xD0 to the command address. Every write address is bus-aligned, and a write and a read never share a cycle.
- R5: The buffer holds 16 bytes by default. Each burst ends at or before the next 16-byte boundary. The following burst resumes at the next word with a fresh sequence, and a full request is cut into as many bursts as it needs.
- R6: The first completion read comes exactly E+1 cycles after the 0xD0 write, where E is a delay estimate that starts at 128 after reset. E drops by 1, never below 1, when that first read already shows ready. It rises by 1 when ready comes on a later read.
- R7: Completion polling allows POLL_LIMIT/2 reads. If none shows ready, the block writes 0x50 and then 0x70 and ends with result 3. Ready on the last allowed read counts as completion.
- R8: On completion, any status bit in mask 0x3A is an error. If bit 1 (0x02) is set the result is 1 (write-protect), otherwise 2 (I/O fault). The block then writes 0x50 and 0x70, and any bursts not yet started are abandoned.
- R9: `done` and `result` stay constant from the end of a request until the cycle after `ack`. `req_ready` is high only while idle. A request with no fault ends with result 0.
- R10: A data word is taken only in a cycle where both `dat_valid` and `dat_ready` are high. While `dat_valid` is low, the sequence pauses with no bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted this cycle |
| req_addr | input | ADDR_W | Start byte address |
| req_count | input | CNT_W | Number of words to program |
| dat_valid | input | 1 | Data word present |
| dat_ready | output | 1 | Data word taken this cycle |
| dat_word | input | DATA_W | Data word |
| done | output | 1 | Request finished, result valid |
| result | output | 3 | 0 ok, 1 write-protect, 2 I/O fault, 3 timeout, 4 misaligned |
| ack | input | 1 | Host acknowledges the result |
| fl_wr | output | 1 | Flash bus write strobe |
| fl_rd | output | 1 | Flash bus status read strobe |
| fl_addr | output | ADDR_W | Flash bus byte address |
| fl_wdata | output | DATA_W | Flash bus write data |
| fl_rdata | input | DATA_W | Flash status, sampled while fl_rd is high |

## Verification
During completion polling, two outcomes can fall on the same read: the device turning ready, and the poll budget running out. The bench arranges both by setting the device's program time so that busy clears exactly on the last permitted completion read. In that case a success result and a rise of the delay estimate are expected, not a timeout. One cycle more of busy must give the timeout path with its clear and status writes. The estimate is judged by the measured gap between the confirm write and the first completion read on the next burst.

// File: rtl/flprog_pkg.sv
package flprog_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_STAT,
        ST_PREPOLL,
        ST_BUFCMD,
        ST_BUFPOLL,
        ST_COUNT,
        ST_DATA,
        ST_CONFIRM,
        ST_WAIT,
        ST_DONEPOLL,
        ST_CLEAR,
        ST_RESTAT,
        ST_REPORT
    } seq_state_t;

    typedef enum logic [2:0] {
        RES_OK       = 3'd0,
        RES_WPROT    = 3'd1,
        RES_IOERR    = 3'd2,
        RES_TIMEOUT  = 3'd3,
        RES_MISALIGN = 3'd4
    } res_t;

    localparam logic [7:0] OP_STATUS  = 8'h70;
    localparam logic [7:0] OP_BUFLOAD = 8'hE8;
    localparam logic [7:0] OP_GO      = 8'hD0;
    localparam logic [7:0] OP_CLEAR   = 8'h50;
    localparam int         RDY_BIT    = 7;
    localparam logic [7:0] FAULT_MASK = 8'h3A;
    localparam logic [7:0] PROT_MASK  = 8'h02;

endpackage

// File: rtl/flprog_span.sv
module flprog_span #(
    parameter int ADDR_W    = 16,
    parameter int CNT_W     = 8,
    parameter int BUS_BYTES = 2,
    parameter int BUF_BYTES = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  left,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [CNT_W-1:0]  burst_len
);
    localparam int BB_LSB    = $clog2(BUS_BYTES);
    localparam int BUF_WORDS = BUF_BYTES / BUS_BYTES;
    localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'(BUF_BYTES - 1);

    logic [ADDR_W-1:0] offset;
    logic [CNT_W-1:0]  room;

    always_comb begin
        cmd_addr  = base & ~OFS_MASK;
        offset    = base & OFS_MASK;
        room      = CNT_W'(BUF_WORDS) - CNT_W'(offset >> BB_LSB);
        burst_len = (left < room) ? left : room;
    end
endmodule

// File: rtl/flprog_est.sv
module flprog_est #(
    parameter int EST_W    = 10,
    parameter int EST_INIT = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic             fast,
    output logic [EST_W-1:0] est
);
    localparam logic [EST_W-1:0] EST_MAX = {EST_W{1'b1}};
    localparam logic [EST_W-1:0] ONE     = EST_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            est <= EST_W'(EST_INIT);
        end else if (upd) begin
            if (fast) begin
                est <= (est > ONE) ? est - ONE : ONE;
            end else begin
                est <= (est == EST_MAX) ? est : est + ONE;
            end
        end
    end
endmodule

// File: rtl/flprog_poll.sv
module flprog_poll #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  logic [CW-1:0] lim,
    output logic [CW-1:0] cnt,
    output logic          hit
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign hit = step && (cnt == lim - CW'(1));
endmodule

// File: rtl/flprog_seq.sv
module flprog_seq
    import flprog_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int CNT_W      = 8,
    parameter int BUS_BYTES  = 2,
    parameter int INTERLEAVE = 1,
    parameter int BUF_EXP    = 4,
    parameter int POLL_LIMIT = 64,
    parameter int EST_INIT   = 128,
    parameter int EST_W      = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  req_count,
    input  logic              dat_valid,
    output logic              dat_ready,
    input  logic [DATA_W-1:0] dat_word,
    output logic              done,
    output logic [2:0]        result,
    input  logic              ack,
    output logic              fl_wr,
    output logic              fl_rd,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_wdata,
    input  logic [DATA_W-1:0] fl_rdata
);
    localparam int BUF_BYTES = INTERLEAVE << BUF_EXP;
    localparam int BB_LSB    = $clog2(BUS_BYTES);
    localparam int POLL_CW   = $clog2(POLL_LIMIT) + 1;
    localparam logic [POLL_CW-1:0] LIM_FULL = POLL_CW'(POLL_LIMIT);
    localparam logic [POLL_CW-1:0] LIM_HALF = POLL_CW'(POLL_LIMIT / 2);
    localparam logic [ADDR_W-1:0]  BW_MASK  = ADDR_W'(BUS_BYTES - 1);
    localparam logic [DATA_W-1:0]  FAULTS   = DATA_W'(FAULT_MASK);
    localparam logic [DATA_W-1:0]  PROTS    = DATA_W'(PROT_MASK);

    seq_state_t state_q, state_d;

    logic [ADDR_W-1:0]  base_q;
    logic [CNT_W-1:0]   left_q;
    logic [CNT_W-1:0]   widx_q;
    logic [EST_W-1:0]   wait_q;
    res_t               res_q;

    logic [ADDR_W-1:0]  cmd_addr;
    logic [CNT_W-1:0]   blen;
    logic [EST_W-1:0]   est_q;
    logic [POLL_CW-1:0] poll_cnt;
    logic [POLL_CW-1:0] poll_lim;
    logic               poll_hit;

    logic dev_ready;
    logic dev_fault;
    logic dev_prot;
    logic misal;
    logic more;
    logic last_word;

    flprog_span #(
        .ADDR_W   (ADDR_W),
        .CNT_W    (CNT_W),
        .BUS_BYTES(BUS_BYTES),
        .BUF_BYTES(BUF_BYTES)
    ) u_span (
        .base     (base_q),
        .left     (left_q),
        .cmd_addr (cmd_addr),
        .burst_len(blen)
    );

    flprog_est #(
        .EST_W   (EST_W),
        .EST_INIT(EST_INIT)
    ) u_est (
        .clk  (clk),
        .rst_n(rst_n),
        .upd  (state_q == ST_DONEPOLL && dev_ready),
        .fast (poll_cnt == '0),
        .est  (est_q)
    );

    flprog_poll #(
        .CW(POLL_CW)
    ) u_poll (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state_q != state_d),
        .step (fl_rd && !dev_ready),
        .lim  (poll_lim),
        .cnt  (poll_cnt),
        .hit  (poll_hit)
    );

    always_comb begin
        dev_ready = fl_rdata[RDY_BIT];
        dev_fault = (fl_rdata & FAULTS) != '0;
        dev_prot  = (fl_rdata & PROTS) != '0;
        misal     = (req_addr & BW_MASK) != '0;
        more      = left_q != blen;
        last_word = widx_q == blen - CNT_W'(1);
        poll_lim  = (state_q == ST_DONEPOLL) ? LIM_HALF : LIM_FULL;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (misal || req_count == '0) state_d = ST_REPORT;
                    else                          state_d = ST_STAT;
                end
            end
            ST_STAT:    state_d = ST_PREPOLL;
            ST_PREPOLL: begin
                if (dev_ready)     state_d = ST_BUFCMD;
                else if (poll_hit) state_d = ST_REPORT;
            end
            ST_BUFCMD:  state_d = ST_BUFPOLL;
            ST_BUFPOLL: begin
                if (dev_ready)     state_d = ST_COUNT;
                else if (poll_hit) state_d = ST_RESTAT;
            end
            ST_COUNT:   state_d = ST_DATA;
            ST_DATA: begin
                if (dat_valid && last_word) state_d = ST_CONFIRM;
            end
            ST_CONFIRM: state_d = ST_WAIT;
            ST_WAIT: begin
                if (wait_q <= EST_W'(1)) state_d = ST_DONEPOLL;
            end
            ST_DONEPOLL: begin
                if (dev_ready) begin
                    if (dev_fault) state_d = ST_CLEAR;
                    else if (more) state_d = ST_STAT;
                    else           state_d = ST_REPORT;
                end else if (poll_hit) begin
                    state_d = ST_CLEAR;
                end
            end
            ST_CLEAR:   state_d = ST_RESTAT;
            ST_RESTAT:  state_d = ST_REPORT;
            ST_REPORT: begin
                if (ack) state_d = ST_IDLE;
            end
            default:    state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            left_q <= '0;
            widx_q <= '0;
            wait_q <= '0;
            res_q  <= RES_OK;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        base_q <= req_addr;
                        left_q <= req_count;
                        widx_q <= '0;
                        res_q  <= misal ? RES_MISALIGN : RES_OK;
                    end
                end
                ST_COUNT:   widx_q <= '0;
                ST_DATA: begin
                    if (dat_valid) widx_q <= widx_q + CNT_W'(1);
                end
                ST_CONFIRM: wait_q <= est_q;
                ST_WAIT:    wait_q <= wait_q - EST_W'(1);
                ST_PREPOLL, ST_BUFPOLL: begin
                    if (!dev_ready && poll_hit) res_q <= RES_TIMEOUT;
                end
                ST_DONEPOLL: begin
                    if (dev_ready) begin
                        if (dev_fault) begin
                            res_q <= dev_prot ? RES_WPROT : RES_IOERR;
                        end else if (more) begin
                            base_q <= base_q + (ADDR_W'(blen) << BB_LSB);
                            left_q <= left_q - blen;
                        end
                    end else if (poll_hit) begin
                        res_q <= RES_TIMEOUT;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        fl_wr     = 1'b0;
        fl_rd     = 1'b0;
        fl_addr   = cmd_addr;
        fl_wdata  = '0;
        req_ready = 1'b0;
        dat_ready = 1'b0;
        done      = 1'b0;
        result    = res_q;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_STAT, ST_RESTAT: begin
                fl_wr    = 1'b1;
                fl_wdata = DATA_W'(OP_STATUS);
            end
            ST_PREPOLL, ST_BUFPOLL, ST_DONEPOLL: fl_rd = 1'b1;
            ST_BUFCMD: begin
                fl_wr    = 1'b1;
                fl_wdata = DATA_W'(OP_BUFLOAD);
            end
            ST_COUNT: begin
                fl_wr    = 1'b1;
                fl_wdata = DATA_W'(blen - CNT_W'(1));
            end
            ST_DATA: begin
                dat_ready = 1'b1;
                fl_wr     = dat_valid;
                fl_addr   = base_q + (ADDR_W'(widx_q) << BB_LSB);
                fl_wdata  = dat_word;
            end
            ST_CONFIRM: begin
                fl_wr    = 1'b1;
                fl_wdata = DATA_W'(OP_GO);
            end
            ST_CLEAR: begin
                fl_wr    = 1'b1;
                fl_wdata = DATA_W'(OP_CLEAR);
            end
            ST_REPORT: done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/flprog_seq_chk.sv
module flprog_seq_chk #(
    parameter int ADDR_W    = 16,
    parameter int BUS_BYTES = 2,
    parameter int EST_W     = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              done,
    input logic [2:0]        result,
    input logic              ack,
    input logic              fl_wr,
    input logic              fl_rd,
    input logic [ADDR_W-1:0] fl_addr,
    input logic [EST_W-1:0]  est
);
    localparam logic [ADDR_W-1:0] BW_MASK = ADDR_W'(BUS_BYTES - 1);

    p_misalign_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_addr & BW_MASK) != '0) |=> (done && result == 3'd4));

    p_excl_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_wr && fl_rd));

    p_bus_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fl_wr |-> ((fl_addr & BW_MASK) == '0));

    p_est_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        est != '0);

    p_hold_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ack) |=> (done && $stable(result)));

    p_idle_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && req_ready));
endmodule

bind flprog_seq flprog_seq_chk #(
    .ADDR_W   (ADDR_W),
    .BUS_BYTES(BUS_BYTES),
    .EST_W    (EST_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_addr (req_addr),
    .done     (done),
    .result   (result),
    .ack      (ack),
    .fl_wr    (fl_wr),
    .fl_rd    (fl_rd),
    .fl_addr  (fl_addr),
    .est      (est_q)
);

// File: tb/flprog_seq_bench.sv
`timescale 1ns/1ps
module flprog_seq_bench;
    localparam int BUFB = 16;
    localparam int LIM  = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        req_valid = 1'b0, req_ready, dat_valid = 1'b0, dat_ready;
    logic [15:0] req_addr = '0, dat_word = '0, fl_addr, fl_wdata, fl_rdata;
    logic [7:0]  req_count = '0;
    logic        done, ack = 1'b0, fl_wr, fl_rd;
    logic [2:0]  result;

    flprog_seq u_flprog_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_count(req_count), .dat_valid(dat_valid),
        .dat_ready(dat_ready), .dat_word(dat_word), .done(done), .result(result),
        .ack(ack), .fl_wr(fl_wr), .fl_rd(fl_rd), .fl_addr(fl_addr),
        .fl_wdata(fl_wdata), .fl_rdata(fl_rdata)
    );

    int nchk = 0, nerr = 0;
    bit finished = 0;

    // device model configuration
    int  prog_time = 0;
    logic [7:0] err_cfg = '0;
    bit  force_busy = 0, buf_busy = 0, mclr = 0;

    // device model state
    int ph = 0, nleft = 0, busy = 0, cyc = 0, t0 = 0, nlog = 0, ngap = 0, didx = 0, nrd = 0;
    logic [7:0] errs = '0;
    bit armed = 0;
    logic [15:0] lga [0:255];
    logic [15:0] lgd [0:255];
    int gaps [0:63];

    int dn = 0;
    logic [15:0] dbuf [0:255];

    // expected
    logic [15:0] ea [0:255];
    logic [15:0] ed [0:255];
    int ne = 0;
    int egap [0:63];
    int neg = 0;
    int est_m = 128;

    wire dev_rdy = !force_busy && busy == 0 && !(ph == 1 && buf_busy);
    assign fl_rdata = dev_rdy ? (16'h0080 | {8'h00, errs}) : 16'h0000;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (dat_valid && dat_ready) didx <= didx + 1;
        if (mclr) begin
            ph <= 0; busy <= 0; errs <= '0; nlog <= 0; ngap <= 0;
            armed <= 0; didx <= 0; nrd <= 0;
        end else begin
            if (busy != 0) busy <= busy - 1;
            if (fl_rd) begin
                nrd <= nrd + 1;
                if (armed) begin
                    gaps[ngap[5:0]] <= cyc - t0;
                    ngap <= ngap + 1;
                    armed <= 0;
                end
            end
            if (fl_wr) begin
                lga[nlog[7:0]] <= fl_addr;
                lgd[nlog[7:0]] <= fl_wdata;
                nlog <= nlog + 1;
                case (ph)
                    0: begin
                        if (fl_wdata == 16'h00E8) ph <= 1;
                        else if (fl_wdata == 16'h0050) errs <= '0;
                    end
                    1: begin nleft <= int'(fl_wdata) + 1; ph <= 2; end
                    2: begin if (nleft == 1) ph <= 3; nleft <= nleft - 1; end
                    default: begin
                        busy <= prog_time; errs <= err_cfg; t0 <= cyc;
                        armed <= 1; ph <= 0;
                    end
                endcase
            end
        end
    end

    always @(negedge clk) begin
        dat_valid = (didx < dn) && ($urandom % 4 != 0);
        dat_word  = dbuf[didx[7:0]];
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
        end
    endtask

    task automatic push(input int a, input int d);
        ea[ne[7:0]] = 16'(a);
        ed[ne[7:0]] = 16'(d);
        ne++;
    endtask

    // sc: 0 normal, 1 pre-poll timeout, 2 buffer timeout, 3 completion timeout, 4 status error
    task automatic build(input int addr, input int cnt, input int sc);
        int rem, a, k, n, room, cmd;
        ne = 0; neg = 0;
        if ((addr % 2) != 0 || cnt == 0) return;
        rem = cnt; a = addr; k = 0;
        while (rem > 0) begin
            cmd = a & ~(BUFB - 1);
            push(cmd, 'h70);
            if (sc == 1) return;
            push(cmd, 'hE8);
            if (sc == 2) begin push(cmd, 'h70); return; end
            room = (BUFB - (a % BUFB)) / 2;
            n = (rem < room) ? rem : room;
            push(cmd, n - 1);
            for (int i = 0; i < n; i++) push(a + 2 * i, int'(dbuf[k + i]));
            push(cmd, 'hD0);
            egap[neg] = est_m + 1; neg++;
            if (sc == 3) begin push(cmd, 'h50); push(cmd, 'h70); return; end
            if (prog_time <= est_m) est_m = (est_m > 1) ? est_m - 1 : 1;
            else est_m = est_m + 1;
            if (sc == 4) begin push(cmd, 'h50); push(cmd, 'h70); return; end
            rem -= n; a += 2 * n; k += n;
        end
    endtask

    task automatic run(input int addr, input int cnt, input int sc,
                       input int eres, input string rq);
        int w, bad;
        for (int i = 0; i < cnt; i++) dbuf[i] = 16'($urandom);
        build(addr, cnt, sc);
        @(negedge clk); mclr = 1; dn = 0;
        @(negedge clk); mclr = 0; dn = cnt;
        req_valid = 1; req_addr = 16'(addr); req_count = 8'(cnt);
        @(negedge clk); req_valid = 0;
        w = 0;
        while (!done && w < 20000) begin @(negedge clk); w++; end
        chk(done && result == 3'(eres), rq, "result", result, eres);
        bad = 0;
        for (int i = 0; i < ne; i++)
            if (lga[i] != ea[i] || lgd[i] != ed[i]) bad++;
        chk(nlog == ne && bad == 0, rq, "bus write sequence", nlog, ne);
        bad = 0;
        for (int i = 0; i < neg; i++) if (gaps[i] != egap[i]) bad++;
        chk(ngap == neg && bad == 0, "R6", "confirm-to-poll gaps", ngap, neg);
        repeat (3) @(negedge clk);
        chk(done && result == 3'(eres) && !req_ready, "R9", "held result", result, eres);
        ack = 1;
        @(negedge clk); ack = 0;
        chk(!done && req_ready, "R9", "released after ack", done, 0);
        dn = 0;
    endtask

    task automatic defaults();
        prog_time = 0; err_cfg = '0; force_busy = 0; buf_busy = 0;
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready && !done && !fl_wr && !fl_rd, "R9", "reset state", {req_ready, done}, 2);

        // R1: misaligned and empty requests
        run('h0103, 4, 0, 4, "R1");
        chk(didx == 0, "R1", "no word taken on misalign", didx, 0);
        run('h0100, 0, 0, 0, "R1");

        // R4: one full buffer; R5: split across boundaries
        run('h0000, 8, 0, 0, "R4");
        run('h000C, 12, 0, 0, "R5");
        run('h0232, 20, 0, 0, "R5");

        // R2: device never ready before start
        force_busy = 1;
        run('h0040, 3, 1, 3, "R2");
        chk(nrd == LIM, "R2", "pre-start reads", nrd, LIM);
        defaults();

        // R3: buffer never ready
        buf_busy = 1;
        run('h0050, 3, 2, 3, "R3");
        defaults();

        // R7: completion timeout, then ready on the very last read
        prog_time = est_m + LIM / 2;
        run('h0060, 3, 3, 3, "R7");
        chk(nrd == 2 + LIM / 2, "R7", "completion reads", nrd, 2 + LIM / 2);
        prog_time = est_m + LIM / 2 - 1;
        run('h0070, 3, 0, 0, "R7");
        defaults();

        // R8: write-protect and general faults abandon later bursts
        err_cfg = 8'h12;
        run('h0088, 10, 4, 1, "R8");
        err_cfg = 8'h28;
        run('h0094, 10, 4, 2, "R8");
        defaults();

        // R6: slow completion raises the estimate
        prog_time = est_m + 5;
        run('h00A0, 2, 0, 0, "R6");
        defaults();

        // R6: drive the estimate to its floor
        for (int i = 0; i < 135; i++) begin
            prog_time = 0;
            run('h0300 + 2 * (i % 8), 1, 0, 0, "R6");
        end
        chk(est_m == 1, "R6", "estimate floor model", est_m, 1);

        // R10 and R4/R5 under random stalls and requests
        for (int i = 0; i < 25; i++) begin
            int a, c;
            a = int'($urandom & 32'h0FFE);
            c = 1 + int'($urandom % 24);
            prog_time = int'($urandom % (est_m + 1));
            run(a, c, 0, 0, "R10");
        end
        defaults();

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL R9 watchdog act=hung exp=done");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end
endmodule